// File: doc/BRIEF.md
# Fracturable LUT Logic Element

This block is a configurable logic element built around one 64-bit truth-table mask. Two mode bits split the mask into different function sizes. It can act as a single 6-input function. It can act as two 5-input functions that share four inputs. It can act as two independent 4-input functions that between them use all eight data inputs. Finally, it can act as a 7-input function, where one input chooses between two 5-input halves.

Each half of the mask is evaluated by a small tree. The tree is built from 3-input lookup sub-blocks, and a 4:1 multiplexer combines their results. Every output can be taken straight from its lookup result or from a flip-flop. Each flip-flop has a clock enable and a synchronous clear.

The configuration is loaded through a write strobe and takes effect at the next clock edge. Until the first load, both outputs stay at 0.

Top module: `flut_le`

## Requirements
- R1: After reset, and until the first configuration write, both outputs are 0 whatever the data inputs, enable and clear do. A later reset returns the block to this state.
- R2: When `cfg_we` is high at a rising edge, the new mask, mode and output selects are captured at that edge. Before the edge the outputs still follow the old configuration; after it they follow the new one.
- R3: Mode 2'b00 (single 6-input): `out0` = mask[din[5:0]]. `out1` is 0, whether it is set to combinational or registered.
- R4: Mode 2'b01 (dual 5-input): `out0` = mask[{din[4],din[3:0]}]. `out1` = mask[32 + {din[5],din[3:0]}]. Inputs din[3:0] are shared by both functions; din[4] and din[5] are each private to one function.
- R5: Mode 2'b10 (dual 4-input): `out0` = mask[din[3:0]]. `out1` = mask[32 + din[7:4]]. `out0` does not depend on din[7:4].
- R6: Mode 2'b11 (7-input): call F1 = mask[{din[4],din[3],din[2],din[1],din[0]}] and F2 = mask[32 + {din[4],din[5],din[3],din[1],din[0]}]. `out0` is F1 when din[6]=0 and F2 when din[6]=1. `out1` is 0.
- R7: When bit k of `cfg_regsel` is 1, output k shows flip-flop k instead of the lookup result. The flip-flop loads the lookup result at a rising edge where `ff_en`=1 and `ff_clr`=0.
- R8: When `ff_clr`=1 at a rising edge, both flip-flops clear to 0. This takes priority over `ff_en`.
- R9: When `ff_en`=0 and `ff_clr`=0 at a rising edge, both flip-flops keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 64 | Truth-table mask to load |
| cfg_mode | input | 2 | Mode to load (00 six-input, 01 dual five, 10 dual four, 11 seven-input) |
| cfg_regsel | input | 2 | Per-output select: 1 = registered, 0 = combinational |
| din | input | 8 | Data inputs |
| ff_en | input | 1 | Flip-flop clock enable |
| ff_clr | input | 1 | Flip-flop synchronous clear |
| out0 | output | 1 | First output |
| out1 | output | 1 | Second output |

## Verification
A wrong input-steering choice in some mode shows up at a combinational output in the same cycle that a data pattern hits an affected mask bit. Random masks and random data expose it within a few cycles of entering that mode. A configuration register that captures late or early shows up as wrong outputs in the first cycle after a write. A flip-flop with wrong enable or clear priority shows up one cycle after the edge, on any output set to registered.

// File: rtl/flut_pkg.sv
package flut_pkg;
  localparam int MASK_W = 64;
  localparam int HALF_W = MASK_W / 2;
  localparam int IDX_W  = $clog2(HALF_W);
  localparam int DIN_W  = 8;
  localparam int NOUT   = 2;

  typedef enum logic [1:0] {
    MODE_L6 = 2'b00,
    MODE_D5 = 2'b01,
    MODE_D4 = 2'b10,
    MODE_X7 = 2'b11
  } mode_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    mode_e             mode;
    logic [NOUT-1:0]   rsel;
  } cfg_t;
endpackage

// File: rtl/flut_cfg.sv
module flut_cfg
  import flut_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MASK_W-1:0] mask_in,
  input  logic [1:0]        mode_in,
  input  logic [NOUT-1:0]   rsel_in,
  output cfg_t              cfg,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      valid <= 1'b0;
    end else if (we) begin
      cfg.mask <= mask_in;
      cfg.mode <= mode_e'(mode_in);
      cfg.rsel <= rsel_in;
      valid    <= 1'b1;
    end
  end

  // R1: once loaded, the element stays configured until reset
  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

  // R2: a write always leaves the element configured at the next edge
  p_write_valid_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> valid);
endmodule

// File: rtl/flut_steer.sv
module flut_steer
  import flut_pkg::*;
(
  input  mode_e             mode,
  input  logic [DIN_W-1:0]  din,
  output logic [IDX_W-1:0]  idx_lo,
  output logic [IDX_W-1:0]  idx_hi,
  output logic              pick_hi,
  output logic              dual
);
  always_comb begin
    idx_lo  = din[IDX_W-1:0];
    idx_hi  = din[IDX_W-1:0];
    pick_hi = 1'b0;
    dual    = 1'b0;
    unique case (mode)
      MODE_L6: begin
        pick_hi = din[5];
      end
      MODE_D5: begin
        idx_lo = {din[4], din[3:0]};
        idx_hi = {din[5], din[3:0]};
        dual   = 1'b1;
      end
      MODE_D4: begin
        idx_lo = {1'b0, din[3:0]};
        idx_hi = {1'b0, din[7:4]};
        dual   = 1'b1;
      end
      MODE_X7: begin
        idx_lo  = {din[4], din[3], din[2], din[1], din[0]};
        idx_hi  = {din[4], din[5], din[3], din[1], din[0]};
        pick_hi = din[6];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flut_half.sv
module flut_half #(
  parameter int IDX_W  = 5,
  parameter int SUB_IN = 3
) (
  input  logic [(1<<IDX_W)-1:0] mask,
  input  logic [IDX_W-1:0]      idx,
  output logic                  q
);
  localparam int SUB_W = 1 << SUB_IN;
  localparam int NSUB  = 1 << (IDX_W - SUB_IN);

  logic [NSUB-1:0] sub_q;

  genvar g;
  generate
    for (g = 0; g < NSUB; g++) begin : g_sub
      logic [SUB_W-1:0] part;
      assign part     = mask[g*SUB_W +: SUB_W];
      assign sub_q[g] = part[idx[SUB_IN-1:0]];
    end
  endgenerate

  assign q = sub_q[idx[IDX_W-1:SUB_IN]];
endmodule

// File: rtl/flut_ostage.sv
module flut_ostage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic d,
  input  logic rsel,
  output logic y
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (en)    q <= d;
  end

  assign y = rsel ? q : d;

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (q == $past(d)));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == 1'b0));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/flut_le.sv
module flut_le
  import flut_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [1:0]        cfg_mode,
  input  logic [NOUT-1:0]   cfg_regsel,
  input  logic [DIN_W-1:0]  din,
  input  logic              ff_en,
  input  logic              ff_clr,
  output logic              out0,
  output logic              out1
);
  cfg_t             cfg;
  logic             valid;
  logic [IDX_W-1:0] idx_lo, idx_hi;
  logic             pick_hi, dual;
  logic             q_lo, q_hi;
  logic [NOUT-1:0]  lut_r;
  logic [NOUT-1:0]  stage_y;

  flut_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .mask_in(cfg_mask),
    .mode_in(cfg_mode), .rsel_in(cfg_regsel), .cfg(cfg), .valid(valid)
  );

  flut_steer u_steer (
    .mode(cfg.mode), .din(din), .idx_lo(idx_lo), .idx_hi(idx_hi),
    .pick_hi(pick_hi), .dual(dual)
  );

  flut_half #(.IDX_W(IDX_W), .SUB_IN(3)) u_lo (
    .mask(cfg.mask[HALF_W-1:0]), .idx(idx_lo), .q(q_lo)
  );

  flut_half #(.IDX_W(IDX_W), .SUB_IN(3)) u_hi (
    .mask(cfg.mask[MASK_W-1:HALF_W]), .idx(idx_hi), .q(q_hi)
  );

  always_comb begin
    lut_r[0] = valid & (dual ? q_lo : (pick_hi ? q_hi : q_lo));
    lut_r[1] = valid & dual & q_hi;
  end

  genvar k;
  generate
    for (k = 0; k < NOUT; k++) begin : g_out
      flut_ostage u_os (
        .clk(clk), .rst(rst), .en(ff_en), .clr(ff_clr),
        .d(lut_r[k]), .rsel(cfg.rsel[k]), .y(stage_y[k])
      );
    end
  endgenerate

  assign out0 = stage_y[0];
  assign out1 = dual & stage_y[1];

  // R1: an unconfigured element drives nothing but zeros
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (out0 == 1'b0 && out1 == 1'b0));

  // R5: in dual 4-input mode out0 ignores the upper four inputs
  p_indep_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && cfg.mode == MODE_D4 && !cfg.rsel[0] && $stable(din[3:0])
     && $stable(cfg) && $stable(valid)) |-> $stable(out0));
endmodule

// File: tb/flut_le_bench.sv
module flut_le_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_mask = '0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_regsel = '0;
  logic [7:0]  din = '0;
  logic        ff_en = 1'b0;
  logic        ff_clr = 1'b0;
  logic        out0, out1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic        m_v;
  logic [63:0] m_mask;
  logic [1:0]  m_mode;
  logic [1:0]  m_rs;
  logic [1:0]  m_ff;
  bit          m_new;
  string       m_fftag;

  always #(CLK_P/2) clk = ~clk;

  flut_le u_flut_le (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .cfg_mode(cfg_mode), .cfg_regsel(cfg_regsel), .din(din),
    .ff_en(ff_en), .ff_clr(ff_clr), .out0(out0), .out1(out1)
  );

  function automatic logic [1:0] f_exp(logic [63:0] m, logic [1:0] md, logic [7:0] d);
    logic [5:0] i0, i1;
    logic [1:0] r;
    case (md)
      2'b00: begin i0 = d[5:0]; r = {1'b0, m[i0]}; end
      2'b01: begin
        i0 = {1'b0, d[4], d[3:0]};
        i1 = {1'b1, d[5], d[3:0]};
        r = {m[i1], m[i0]};
      end
      2'b10: begin
        i0 = {2'b00, d[3:0]};
        i1 = {2'b10, d[7:4]};
        r = {m[i1], m[i0]};
      end
      default: begin
        i0 = {1'b0, d[4], d[3], d[2], d[1], d[0]};
        i1 = {1'b1, d[4], d[5], d[3], d[1], d[0]};
        r = {1'b0, (d[6] ? m[i1] : m[i0])};
      end
    endcase
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] md);
    case (md)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_outs();
    logic [1:0] c, e, a;
    c = f_exp(m_mask, m_mode, din);
    a = {out1, out0};
    for (int k = 0; k < 2; k++) begin
      string tg;
      if (!m_v) e[k] = 1'b0;
      else if (k == 1 && (m_mode == 2'b00 || m_mode == 2'b11)) e[k] = 1'b0;
      else e[k] = m_rs[k] ? m_ff[k] : c[k];
      if (!m_v) tg = "R1";
      else if (m_new) tg = "R2";
      else if (m_rs[k] && !(k == 1 && (m_mode == 2'b00 || m_mode == 2'b11))) tg = m_fftag;
      else tg = mode_tag(m_mode);
      total++;
      if (a[k] !== e[k]) begin
        bad++;
        $display("FAIL %s out%0d actual=%b expected=%b mode=%b din=%h", tg, k, a[k], e[k], m_mode, din);
      end
    end
  endtask

  task automatic cyc(logic we, logic [63:0] msk, logic [1:0] md, logic [1:0] rs,
                     logic [7:0] d, logic en, logic clr, logic r);
    logic [1:0] c;
    rst = r; cfg_we = we; cfg_mask = msk; cfg_mode = md; cfg_regsel = rs;
    din = d; ff_en = en; ff_clr = clr;
    #(CLK_P/4);
    check_outs();
    @(posedge clk);
    c = m_v ? f_exp(m_mask, m_mode, din) : 2'b00;
    if (m_mode == 2'b00 || m_mode == 2'b11) c[1] = 1'b0;
    m_new = 0;
    if (r) begin
      m_v = 0; m_mask = '0; m_mode = '0; m_rs = '0; m_ff = '0; m_fftag = "R7";
    end else begin
      if (clr) begin m_ff = 2'b00; m_fftag = "R8"; end
      else if (en) begin m_ff = c; m_fftag = "R7"; end
      else m_fftag = "R9";
      if (we) begin
        m_v = 1; m_mask = msk; m_mode = md; m_rs = rs; m_new = 1;
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [63:0] rmask();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    m_v = 0; m_mask = '0; m_mode = '0; m_rs = '0; m_ff = '0; m_new = 0; m_fftag = "R7";
    @(negedge clk);
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 0, 0, 1);
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 0, 0, 0);
    // R1: unconfigured element with busy inputs
    for (int i = 0; i < 20; i++)
      cyc(0, rmask(), 2'($urandom()), 2'($urandom()), 8'($urandom()), 1'($urandom()), 0, 0);
    // R2: write, checked before and after the capturing edge
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 2'b00, 8'h15, 1, 0, 0);
    cyc(0, '0, 2'b00, 2'b00, 8'h15, 1, 0, 0);
    // R6 directed: low half zero, high half ones -> out0 follows din[6]
    cyc(1, 64'hFFFF_FFFF_0000_0000, 2'b11, 2'b00, 8'h00, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, '0, 2'b00, 2'b00, 8'($urandom()), 0, 0, 0);
    // R8 directed: clear together with enable
    cyc(1, 64'h0000_FFFF_0000_FFFF, 2'b10, 2'b11, 8'h00, 0, 0, 0);
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 1, 0, 0);
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 1, 1, 0);
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 0, 0, 0);
    // random sweep of every mode
    for (int md = 0; md < 4; md++) begin
      cyc(1, rmask(), 2'(md), 2'($urandom()), 8'($urandom()), 0, 0, 0);
      for (int i = 0; i < 250; i++) begin
        logic w;
        w = ($urandom() % 40) == 0;
        cyc(w, rmask(), 2'(md), 2'($urandom()), 8'($urandom()),
            1'($urandom()), (($urandom() % 8) == 0), 0);
      end
    end
    // R1: a later reset returns to the unconfigured state
    cyc(0, '0, 2'b00, 2'b00, 8'h00, 0, 0, 1);
    for (int i = 0; i < 6; i++)
      cyc(0, '0, 2'b00, 2'b00, 8'($urandom()), 1, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule